// File: doc/BRIEF.md
# SAR ADC Serial Readout Port

This block is the converter-side digital port of a 16-bit successive-approximation ADC. A rising edge on the convert-start input ends acquisition and starts a conversion. On that same edge the block samples the serial data input and the serial clock. SDI high chooses a select-gated readout, in which SDO is tri-stated unless the host selects the device. SDI low chooses a chained readout, in which SDO is always driven and data from upstream converters follows this device's word. In chained readout the serial clock level chooses whether a leading busy slot comes before the data.

All pins are oversampled in a fast system clock domain. Convert-start rising edges and serial-clock falling edges are detected after a synchronizer. A behavioural conversion stub latches the `sample_i` word at the start edge and delivers it after a fixed number of cycles. The port returns to acquisition while the word is read out. SDO is presented as a value plus an output enable, so a board-level tri-state buffer or a bench can use the two directly.

In select-gated readout, the SDI level when the conversion finishes decides between a plain 16-slot readout and a 17-slot readout. The 17-slot readout begins with a low busy slot that signals completion.

Top module: `sar_ifc`

## Requirements
- R1: When SDI is high at a convert-start rising edge, the select-gated readout is chosen, and `sdo_oe_o` is 0 from that edge until the conversion completes, whatever SDI does.
- R2: When SDI is low at a convert-start rising edge, the chained readout is chosen and `sdo_oe_o` stays 1 from then on. `sdo_o` is 0 while the conversion runs.
- R3: In chained readout, a low serial clock at the start edge puts the result MSB on SDO as soon as the conversion completes. A high serial clock makes a busy slot precede the data.
- R4: While convert-start and SDI are both low, SDO is driven (`sdo_oe_o`=1) at 0 in every mode.
- R5: Select-gated, SDI high at completion: SDO stays tri-stated until SDI goes low. It then shows D15, and each serial-clock falling edge brings the next lower bit. SDO is tri-stated again after the 16th falling edge.
- R6: Select-gated, SDI low at completion: SDO becomes driven at 0 when the conversion completes. The 1st to 16th falling edges then bring D15 down to D0, and the 17th falling edge tri-states SDO.
- R7: A new convert-start rising edge in select-gated readout abandons an unfinished readout and tri-states SDO. The old bits are not resumed.
- R8: In chained readout, each serial-clock falling edge shifts the word one place toward the MSB, and the SDI level enters the LSB. After 16 data edges, the upstream bits appear on SDO in the order received.
- R9: In chained readout with busy slot, SDO stays 0 after completion until SDI is seen high. SDO then shows 1. The next falling edge replaces it with D15 and does not capture SDI.
- R10: The result is the `sample_i` value at the start edge and is not shown before `CONV_CYCLES` cycles. Serial-clock falling edges during the conversion move nothing.
- R11: After reset, with convert-start and SDI held high, `sdo_oe_o` is 0 and no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, fast relative to the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert-start pin; rising edge starts a conversion |
| sdi_i | input | 1 | Serial data / select input |
| sclk_i | input | 1 | Serial clock; falling edges advance readout |
| sample_i | input | DATA_W | Stand-in for the analog value, latched at start |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | SDO drive enable; 0 means high impedance |

## Verification
The bench targets the 16th and 17th falling edges. A design that miscounts the busy slot releases SDO one bit early or one bit late, and the check right after that edge sees the wrong drive state. It re-triggers a conversion in the middle of a readout and then drops SDI. A port that does not clear its readout on the start edge would drive stale bits. In the chained cases it feeds known upstream bits. A design that takes SDI during the busy slot, or shifts on edges during conversion, delivers a displaced upstream word or a wrong first data bit. It changes `sample_i` while a conversion runs. A design that reads the live value instead of the latched one shows the new word.

// File: rtl/sar_ifc_pkg.sv
package sar_ifc_pkg;
  typedef struct packed {
    logic chain;  // chained readout selected
    logic busy;   // leading busy slot in chained readout
  } sar_mode_t;
endpackage

// File: rtl/sar_ifc_sync.sv
module sar_ifc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sar_ifc_conv.sv
module sar_ifc_conv #(
  parameter int W      = 16,
  parameter int CYCLES = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] sample_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W-1:0]  res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; res_q <= '0;
    end else if (start_i) begin
      res_q <= sample_i; cnt_q <= CW'(CYCLES); busy_q <= 1'b1; done_q <= 1'b0;
    end else begin
      done_q <= busy_q && (cnt_q == CW'(1));
      if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  p_done_follows_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/sar_ifc_shift.sv
module sar_ifc_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         lead_i,
  input  logic         step_i,
  input  logic         ser_i,
  output logic         msb_o,
  output logic         lead_o,
  output logic         spent_o
);
  localparam int CW = $clog2(W + 2);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          lead_q, used_q;
  logic [CW-1:0] limit;

  assign limit   = used_q ? CW'(W + 1) : CW'(W);
  assign spent_o = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; cnt_q <= CW'(W + 1); lead_q <= 1'b0; used_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= CW'(W + 1); lead_q <= 1'b0; used_q <= 1'b0;
    end else if (load_i) begin
      sr_q <= data_i; cnt_q <= '0; lead_q <= lead_i; used_q <= lead_i;
    end else if (step_i) begin
      if (lead_q) lead_q <= 1'b0;               // busy slot consumes one edge
      else        sr_q   <= {sr_q[W-2:0], ser_i};
      if (!spent_o) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign msb_o  = sr_q[W-1];
  assign lead_o = lead_q;

  p_lead_no_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && lead_o && !clear_i && !load_i) |=> ($stable(sr_q) && !lead_o));
endmodule

// File: rtl/sar_ifc.sv
module sar_ifc
  import sar_ifc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sdi_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int          NPIN    = 3;
  localparam logic [2:0]  PIN_RST = 3'b011;  // {sclk, sdi, cnv} idle levels

  logic [NPIN-1:0] pin_raw, pin_s;
  assign pin_raw = {sclk_i, sdi_i, cnv_i};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    sar_ifc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[i])) u_sync (
      .clk_i, .rst_ni, .d_i(pin_raw[i]), .q_o(pin_s[i])
    );
  end

  logic cnv_s, sdi_s, sclk_s;
  assign {sclk_s, sdi_s, cnv_s} = pin_s;

  logic cnv_prev_q, sclk_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin cnv_prev_q <= 1'b1; sclk_prev_q <= 1'b0; end
    else         begin cnv_prev_q <= cnv_s; sclk_prev_q <= sclk_s; end
  end

  logic cnv_rise, sclk_fall;
  assign cnv_rise  = cnv_s && !cnv_prev_q;
  assign sclk_fall = !sclk_s && sclk_prev_q;

  // conversion stub
  logic              conv_busy, conv_done;
  logic [DATA_W-1:0] conv_res;
  sar_ifc_conv #(.W(DATA_W), .CYCLES(CONV_CYCLES)) u_conv (
    .clk_i, .rst_ni, .start_i(cnv_rise), .sample_i,
    .busy_o(conv_busy), .done_o(conv_done), .result_o(conv_res)
  );

  // mode and phase state
  sar_mode_t mode_q;
  logic      data_rdy_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; data_rdy_q <= 1'b0; armed_q <= 1'b0;
    end else if (cnv_rise) begin
      mode_q.chain <= !sdi_s;
      mode_q.busy  <= !sdi_s && sclk_s;
      data_rdy_q   <= 1'b0;
      armed_q      <= 1'b0;
    end else begin
      if (conv_done) data_rdy_q <= 1'b1;
      if (mode_q.chain && mode_q.busy && data_rdy_q && sdi_s) armed_q <= 1'b1;
    end
  end

  // readout register
  logic sh_msb, sh_lead, sh_spent, step, load_lead;
  logic cs_sel, chain_show;

  assign load_lead  = mode_q.chain ? mode_q.busy : !sdi_s;
  assign cs_sel     = !mode_q.chain && data_rdy_q && !sdi_s && !sh_spent;
  assign chain_show = mode_q.chain && data_rdy_q && (!mode_q.busy || armed_q);
  assign step       = sclk_fall && (mode_q.chain ? chain_show : cs_sel);

  sar_ifc_shift #(.W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .clear_i(cnv_rise), .load_i(conv_done), .data_i(conv_res),
    .lead_i(load_lead), .step_i(step), .ser_i(sdi_s),
    .msb_o(sh_msb), .lead_o(sh_lead), .spent_o(sh_spent)
  );

  // SDO drive
  always_comb begin
    sdo_oe_o = 1'b0;
    sdo_o    = 1'b0;
    if (!cnv_s && !sdi_s) begin
      sdo_oe_o = 1'b1;
    end else if (mode_q.chain) begin
      sdo_oe_o = 1'b1;
      if (chain_show) sdo_o = sh_lead ? 1'b1 : sh_msb;
    end else if (cs_sel) begin
      sdo_oe_o = 1'b1;
      sdo_o    = sh_lead ? 1'b0 : sh_msb;
    end
  end

  p_hiz_after_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_rise && sdi_s) |=> !sdo_oe_o);
  p_chain_quiet_conv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.chain && conv_busy) |-> (sdo_oe_o && !sdo_o));
  p_force_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnv_s && !sdi_s) |-> (sdo_oe_o && !sdo_o));
  p_cs_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.chain && cnv_s && $rose(sh_spent)) |-> !sdo_oe_o);
  p_arm_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(sdi_s));
  p_no_step_conv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_busy |-> !step);
endmodule

// File: tb/sar_ifc_tb.sv
module sar_ifc_tb;
  localparam int W    = 16;
  localparam int CONV = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b1, sdi = 1'b1, sclk = 1'b0;
  logic [W-1:0] sample = '0;
  logic sdo, sdo_oe;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  sar_ifc #(.DATA_W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .sdi_i(sdi), .sclk_i(sclk),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  // scoreboard queues
  logic  q_oe[$];
  logic  q_val[$];
  string q_tag[$];

  task automatic push(input logic oe, input logic v, input string tag);
    q_oe.push_back(oe); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic monitor();
    logic eo, ev; string t;
    eo = q_oe.pop_front(); ev = q_val.pop_front(); t = q_tag.pop_front();
    checks++;
    if (sdo_oe !== eo || (eo && sdo !== ev)) begin
      errors++;
      $display("FAIL %s: oe=%b sdo=%b expected oe=%b sdo=%b", t, sdo_oe, sdo, eo, ev);
    end
  endtask

  task automatic expect_out(input logic oe, input logic v, input string tag);
    push(oe, v, tag);
    monitor();
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_conv();
    repeat (CONV + 10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fall_edge();
    sclk = 1'b1; settle();
    sclk = 1'b0; settle();
  endtask

  task automatic start(input logic sdi_lvl, input logic sclk_lvl, input logic [W-1:0] val);
    sample = val; sdi = sdi_lvl; sclk = sclk_lvl;
    cnv = 1'b0; settle();
    cnv = 1'b1; settle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d, u;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    settle();
    expect_out(1'b0, 1'b0, "R11 idle after reset");

    // R5: select-gated, SDI high at completion
    d = 16'hB3C5;
    start(1'b1, 1'b0, d);
    expect_out(1'b0, 1'b0, "R1 hiz in conversion");
    wait_conv();
    expect_out(1'b0, 1'b0, "R5 hiz until selected");
    sdi = 1'b0; settle();
    expect_out(1'b1, d[15], "R5 msb on select");
    for (int i = 1; i < 16; i++) begin
      fall_edge();
      expect_out(1'b1, d[15-i], "R5 data bit");
    end
    fall_edge();
    expect_out(1'b0, 1'b0, "R5 release after 16th edge");
    sdi = 1'b1; settle();

    // R6: select-gated, SDI low at completion -> busy slot
    d = 16'h5A0F;
    start(1'b1, 1'b0, d);
    sdi = 1'b0; settle();
    expect_out(1'b0, 1'b0, "R1 hiz in conversion with SDI low");
    wait_conv();
    expect_out(1'b1, 1'b0, "R6 busy slot low");
    for (int i = 0; i < 16; i++) begin
      fall_edge();
      expect_out(1'b1, d[15-i], "R6 data bit");
    end
    fall_edge();
    expect_out(1'b0, 1'b0, "R6 release after 17th edge");

    // R7: abort mid-readout
    sdi = 1'b1; settle();
    d = 16'hF00D;
    start(1'b1, 1'b0, d);
    wait_conv();
    sdi = 1'b0; settle();
    fall_edge(); fall_edge();
    expect_out(1'b1, d[13], "R7 readout in progress");
    sdi = 1'b1; settle();
    cnv = 1'b0; settle();
    cnv = 1'b1; @(posedge clk); @(posedge clk); @(posedge clk);
    sdi = 1'b0; settle();
    expect_out(1'b0, 1'b0, "R7 hiz after new start");
    wait_conv();
    sdi = 1'b1; settle();

    // R2/R3/R8/R10: chained, no busy slot
    d = 16'h9C61; u = 16'hA5E7;
    sample = d; sdi = 1'b0; sclk = 1'b0; cnv = 1'b0; settle();
    expect_out(1'b1, 1'b0, "R4 forced low");
    cnv = 1'b1; settle();
    sample = 16'h0000;
    expect_out(1'b1, 1'b0, "R2 driven low in conversion");
    fall_edge();
    repeat (CONV / 4) @(posedge clk);
    @(negedge clk);
    expect_out(1'b1, 1'b0, "R10 no data before conversion ends");
    wait_conv();
    expect_out(1'b1, d[15], "R3 msb without busy slot");
    for (int i = 1; i <= 20; i++) begin
      sdi = (i <= 16) ? u[16-i] : 1'b0;
      fall_edge();
      if (i < 16) expect_out(1'b1, d[15-i], "R8 own bit");
      else        expect_out(1'b1, u[31-i], "R8 upstream bit");
    end

    // R3/R9: chained with busy slot
    d = 16'h3E94; u = 16'h6B2D;
    sample = d; sdi = 1'b0; sclk = 1'b1; cnv = 1'b0; settle();
    cnv = 1'b1; settle();
    sclk = 1'b0; settle();
    wait_conv();
    expect_out(1'b1, 1'b0, "R9 low without busy enable");
    sdi = 1'b1; settle();
    expect_out(1'b1, 1'b1, "R3 busy slot shown");
    fall_edge();
    expect_out(1'b1, d[15], "R9 msb after busy slot");
    for (int i = 2; i <= 20; i++) begin
      sdi = (i <= 17) ? u[17-i] : 1'b0;
      fall_edge();
      if (i <= 16) expect_out(1'b1, d[16-i], "R9 own bit");
      else         expect_out(1'b1, u[32-i], "R8 upstream bit after busy");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule